// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block prepares the second operand of an arithmetic or logic operation, or the register offset of an address. It takes a data word, a shift kind, a 5-bit amount and the current carry flag. It returns the shifted word and the carry that the flag logic should use. The block supports four ordinary shifts: logical left, logical right, arithmetic right and rotate right. It also has a one-bit rotate that passes through the carry flag. A separate immediate path builds a full-width operand from an 8-bit unsigned constant, which it rotates right by twice a 4-bit rotate field.

The shift and selection logic is combinational. One output register follows it, so both results appear one clock after the inputs. Any shift by a nonzero amount reports the last bit that left the word as the carry. A zero amount passes the word through and keeps the incoming carry.

Top module: `operand_shifter`

## Requirements
- R1: While `rst_n` is low, `result_o` and `carry_o` are 0.
- R2: Both outputs reflect the inputs present at the previous rising clock edge, a latency of exactly one cycle.
- R3: For kind codes 0 to 3 (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right) with `amount_i` = 0, the result equals `value_i` and the carry equals `carry_i`.
- R4: Kind 0 with amount n in 1..31 gives `value_i` shifted left by n with zeros entering bit 0. The carry is bit 32-n of `value_i`. A shift by 4 multiplies the value by 16 modulo 2^32.
- R5: Kind 1 with amount n in 1..31 gives `value_i` shifted right by n with zeros entering bit 31. The carry is bit n-1 of `value_i`.
- R6: Kind 2 with amount n in 1..31 gives `value_i` shifted right by n, with copies of bit 31 filling the vacated bits. The carry is bit n-1 of `value_i`.
- R7: Kind 3 with amount n in 1..31 rotates `value_i` right by n. The carry equals bit 31 of the rotated result.
- R8: Kind 4 rotates the 33-bit concatenation of `carry_i` and `value_i` right by exactly one place. The result is {carry_i, value_i[31:1]} and the carry is `value_i[0]`. `amount_i` has no effect.
- R9: Kind 5 zero-extends `imm_i` to 32 bits and rotates it right by 2 x `rot_i`. The carry is bit 31 of that result when `rot_i` is nonzero, and `carry_i` when `rot_i` is 0. `value_i` and `amount_i` have no effect.
- R10: Kind codes 6 and 7 pass `value_i` through unchanged and return `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| kind_i | input | 3 | Shift kind code |
| amount_i | input | 5 | Shift or rotate amount |
| value_i | input | 32 | Word to be shifted |
| imm_i | input | 8 | Unsigned constant for the immediate kind |
| rot_i | input | 4 | Immediate rotate field; rotation is twice this value |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Registered shifted operand |
| carry_o | output | 1 | Registered carry-out |

## Verification
The result and the carry of every kind are due exactly one rising edge after the inputs are applied. The bench changes the inputs on falling edges and stores the expected pair in a queue. On the next falling edge it removes that pair and compares it with the outputs, so each comparison samples the register one edge after the stimulus that produced it. The reference model shifts or rotates one bit at a time and records the last bit that leaves the word, which keeps it independent of the single-step barrel logic in the design.

// File: rtl/osh_pkg.sv
package osh_pkg;
    typedef enum logic [2:0] {
        SK_LSL  = 3'd0,
        SK_LSR  = 3'd1,
        SK_ASR  = 3'd2,
        SK_ROR  = 3'd3,
        SK_RRX  = 3'd4,
        SK_IMM  = 3'd5,
        SK_RSV6 = 3'd6,
        SK_RSV7 = 3'd7
    } shift_kind_e;
endpackage

// File: rtl/osh_barrel.sv
module osh_barrel
    import osh_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amt,
    input  logic [WIDTH-1:0]  value,
    input  logic              carry_in,
    output logic [WIDTH-1:0]  res,
    output logic              cout
);
    localparam logic [AMT_W:0] WIDTH_EXT = (AMT_W+1)'(WIDTH);

    logic [AMT_W:0]     left_idx;
    logic [AMT_W-1:0]   right_idx;
    logic [2*WIDTH-1:0] doubled;
    logic               amt_zero;

    always_comb begin
        amt_zero  = (amt == '0);
        left_idx  = WIDTH_EXT - {1'b0, amt};
        right_idx = amt - 1'b1;
        doubled   = {value, value} >> amt;
    end

    always_comb begin
        res  = value;
        cout = carry_in;
        unique case (kind)
            SK_LSL: if (!amt_zero) begin
                res  = value << amt;
                cout = value[left_idx[AMT_W-1:0]];
            end
            SK_LSR: if (!amt_zero) begin
                res  = value >> amt;
                cout = value[right_idx];
            end
            SK_ASR: if (!amt_zero) begin
                res  = WIDTH'($signed(value) >>> amt);
                cout = value[right_idx];
            end
            SK_ROR: if (!amt_zero) begin
                res  = doubled[WIDTH-1:0];
                cout = doubled[WIDTH-1];
            end
            SK_RRX: begin
                res  = {carry_in, value[WIDTH-1:1]};
                cout = value[0];
            end
            default: begin
                res  = value;
                cout = carry_in;
            end
        endcase
    end
endmodule

// File: rtl/osh_imm_expand.sv
module osh_imm_expand #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [ROT_W-1:0] rot,
    input  logic             carry_in,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int RAMT_W = ROT_W + 1;

    logic [WIDTH-1:0]   ext;
    logic [RAMT_W-1:0]  ramt;
    logic [2*WIDTH-1:0] doubled;

    always_comb begin
        ext     = {{(WIDTH-IMM_W){1'b0}}, imm};
        ramt    = {rot, 1'b0};
        doubled = {ext, ext} >> ramt;
        res     = doubled[WIDTH-1:0];
        cout    = (rot == '0) ? carry_in : doubled[WIDTH-1];
    end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import osh_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH),
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       kind_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic [WIDTH-1:0] value_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [ROT_W-1:0] rot_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    shift_kind_e      kind;
    logic [WIDTH-1:0] bar_res, imm_res, sel_res;
    logic             bar_c, imm_c, sel_c;

    assign kind = shift_kind_e'(kind_i);

    osh_barrel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) barrel_i (
        .kind     (kind),
        .amt      (amount_i),
        .value    (value_i),
        .carry_in (carry_i),
        .res      (bar_res),
        .cout     (bar_c)
    );

    osh_imm_expand #(.WIDTH(WIDTH), .IMM_W(IMM_W), .ROT_W(ROT_W)) imm_i_u (
        .imm      (imm_i),
        .rot      (rot_i),
        .carry_in (carry_i),
        .res      (imm_res),
        .cout     (imm_c)
    );

    always_comb begin
        if (kind == SK_IMM) begin
            sel_res = imm_res;
            sel_c   = imm_c;
        end else begin
            sel_res = bar_res;
            sel_c   = bar_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
        end else begin
            result_o <= sel_res;
            carry_o  <= sel_c;
        end
    end
endmodule

// File: rtl/osh_checker.sv
module osh_checker #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH),
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       kind_i,
    input logic [AMT_W-1:0] amount_i,
    input logic [WIDTH-1:0] value_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [ROT_W-1:0] rot_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o
);
    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (result_o == '0 && carry_o == 1'b0); // R1
        end
    end

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) < 3'd4 && $past(amount_i) == '0)
        |-> (result_o == $past(value_i) && carry_o == $past(carry_i))); // R3

    AST_LSL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 3'd0 && $past(amount_i) != '0)
        |-> (result_o[0] == 1'b0)); // R4

    AST_ASR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 3'd2)
        |-> (result_o[WIDTH-1] == $past(value_i[WIDTH-1]))); // R6

    AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 3'd3 && $past(amount_i) != '0)
        |-> (carry_o == result_o[WIDTH-1])); // R7

    AST_RRX_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 3'd4)
        |-> (result_o[WIDTH-1] == $past(carry_i) && carry_o == $past(value_i[0]))); // R8

    AST_IMM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 3'd5 && $past(rot_i) != '0)
        |-> (carry_o == result_o[WIDTH-1])); // R9

    AST_RSV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) >= 3'd6)
        |-> (result_o == $past(value_i) && carry_o == $past(carry_i))); // R10

    AST_IMM_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 3'd5)
        |-> ($countones(result_o) == $countones($past(imm_i)))); // R9
endmodule

bind operand_shifter osh_checker #(
    .WIDTH(WIDTH), .AMT_W(AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) chk_i (.*);

// File: tb/operand_shifter_tb_top.sv
`timescale 1ns/1ps
module operand_shifter_tb_top;
    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  kind_i = '0;
    logic [4:0]  amount_i = '0;
    logic [31:0] value_i = '0;
    logic [7:0]  imm_i = '0;
    logic [3:0]  rot_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        c;
        string       tag;
    } exp_t;
    exp_t pending[$];

    always #2.5 clk = ~clk;

    operand_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .kind_i(kind_i), .amount_i(amount_i),
        .value_i(value_i), .imm_i(imm_i), .rot_i(rot_i), .carry_i(carry_i),
        .result_o(result_o), .carry_o(carry_o)
    );

    // Bit-at-a-time reference: each step records the bit that leaves.
    function automatic exp_t model(input int k, input int n, input logic [31:0] v,
                                   input logic [7:0] im, input int r, input logic ci,
                                   input string tag);
        exp_t e;
        logic [31:0] w = v;
        logic c = ci;
        case (k)
            0: for (int i = 0; i < n; i++) begin c = w[31]; w = {w[30:0], 1'b0}; end
            1: for (int i = 0; i < n; i++) begin c = w[0]; w = {1'b0, w[31:1]}; end
            2: for (int i = 0; i < n; i++) begin c = w[0]; w = {w[31], w[31:1]}; end
            3: for (int i = 0; i < n; i++) begin c = w[0]; w = {w[0], w[31:1]}; end
            4: begin c = v[0]; w = {ci, v[31:1]}; end
            5: begin
                w = {24'd0, im};
                for (int i = 0; i < 2*r; i++) begin c = w[0]; w = {w[0], w[31:1]}; end
            end
            default: ;
        endcase
        e.res = w; e.c = c; e.tag = tag;
        return e;
    endfunction

    task automatic compare_due();
        exp_t e;
        if (pending.size() == 0) return;
        e = pending.pop_front();
        checks++;
        if (result_o !== e.res || carry_o !== e.c) begin
            errors++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     e.tag, result_o, carry_o, e.res, e.c);
        end
    endtask

    task automatic apply(input int k, input int n, input logic [31:0] v,
                         input logic [7:0] im, input int r, input logic ci,
                         input string tag);
        @(negedge clk);
        compare_due();
        kind_i = 3'(k); amount_i = 5'(n); value_i = v; imm_i = im;
        rot_i = 4'(r); carry_i = ci;
        pending.push_back(model(k, n, v, im, r, ci, tag));
    endtask

    task automatic drain();
        @(negedge clk);
        compare_due();
    endtask

    function automatic string tag_of(input int k, input int n);
        if (k < 4 && n == 0) return "R3";
        case (k)
            0: return "R4"; 1: return "R5"; 2: return "R6"; 3: return "R7";
            4: return "R8"; 5: return "R9"; default: return "R10";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        kind_i = 3'd0; amount_i = 5'd4; value_i = 32'hFFFF_FFFF; carry_i = 1'b1;
        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if (result_o !== 32'h0 || carry_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: result=%h carry=%b expected result=00000000 carry=0",
                     result_o, carry_o);
        end
        rst_n = 1'b1;

        // R2: one-cycle latency across back-to-back distinct inputs
        apply(1, 8, 32'h1234_5678, 8'h0, 0, 1'b0, "R2");
        apply(1, 4, 32'h1234_5678, 8'h0, 0, 1'b0, "R2");
        // R3 zero amounts keep carry_in
        apply(0, 0, 32'hDEAD_BEEF, 8'h0, 0, 1'b1, "R3");
        apply(2, 0, 32'h8000_0001, 8'h0, 0, 1'b0, "R3");
        apply(3, 0, 32'hCAFE_F00D, 8'h0, 0, 1'b1, "R3");
        // R4 left by 4 is x16; edges 1 and 31
        apply(0, 4, 32'h0000_0123, 8'h0, 0, 1'b0, "R4");
        apply(0, 1, 32'h8000_0000, 8'h0, 0, 1'b0, "R4");
        apply(0, 31, 32'h0000_0003, 8'h0, 0, 1'b1, "R4");
        // R5
        apply(1, 1, 32'h0000_0001, 8'h0, 0, 1'b0, "R5");
        apply(1, 31, 32'hC000_0000, 8'h0, 0, 1'b0, "R5");
        // R6 negative and positive
        apply(2, 4, 32'h8000_0010, 8'h0, 0, 1'b0, "R6");
        apply(2, 31, 32'h4000_0000, 8'h0, 0, 1'b1, "R6");
        // R7
        apply(3, 8, 32'h0000_0080, 8'h0, 0, 1'b0, "R7");
        apply(3, 1, 32'h0000_0002, 8'h0, 0, 1'b1, "R7");
        // R8 amount has no effect
        apply(4, 0, 32'h0000_0001, 8'h0, 0, 1'b1, "R8");
        apply(4, 17, 32'h0000_0002, 8'h0, 0, 1'b0, "R8");
        // R9 rotation zero keeps carry; nonzero rotations; value ignored
        apply(5, 9, 32'hFFFF_FFFF, 8'hFF, 0, 1'b1, "R9");
        apply(5, 0, 32'h0, 8'h01, 1, 1'b0, "R9");
        apply(5, 3, 32'h0, 8'h81, 4, 1'b1, "R9");
        apply(5, 0, 32'h0, 8'h3C, 15, 1'b0, "R9");
        // R10 reserved codes
        apply(6, 5, 32'h5A5A_A5A5, 8'h11, 3, 1'b1, "R10");
        apply(7, 12, 32'h0F0F_0F0F, 8'h22, 2, 1'b0, "R10");

        for (int i = 0; i < 600; i++) begin
            int k = int'($urandom_range(0, 7));
            int n = int'($urandom_range(0, 31));
            apply(k, n, $urandom(), 8'($urandom()), int'($urandom_range(0, 15)),
                  1'($urandom()), tag_of(k, n));
        end
        drain();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule